// File: doc/BRIEF.md
# Protected-Write System Clock Divider

This block slows the system clock of a chip by a power-of-two factor so that power drops when little processing is needed. It counts master clock cycles and sends out a one-cycle clock enable that the CPU, the I/O logic and the flash interface all use together. It also drives an optional divided clock pin. Any master clock source can feed it.

The division factor is stored in an 8-bit control register. Software can change it only through a two-write unlock sequence. The first write opens a short window. A second write, made inside that window, sets the new factor. A write made at any other time leaves the factor as it is. While the window is open the block raises an interrupt mask, so that an interrupt cannot stretch the sequence past its deadline. A new factor waits for the end of the current divided period before it takes effect. Because of this, no system clock period is ever cut short.

Top module: `sysclk_prescaler`

## Requirements
- R1: During reset and right after it, the select field holds the value on `rst_sel_i`, the unlock bit reads 0 and `irq_mask_o` is 0. A strap value above 8 loads 0.
- R2: `rd_data_o` always shows the unlock bit at bit 7, zeros at bits 6..4 and the select field at bits 3..0.
- R3: Only a write of exactly 8'h80 sets the unlock bit. A write with bit 7 set and any other bit set changes nothing.
- R4: A write with bit 7 at 0 changes the select field only when the unlock bit is set at the clock edge where the write is taken. Any other such write is ignored.
- R5: The unlock bit stays set for four clock cycles after the write that set it, and then clears. An accepted select write clears it at that same edge.
- R6: Writing 8'h80 again while the window is open starts a new four-cycle window.
- R7: `irq_mask_o` is high exactly while the unlock bit is set.
- R8: A select write inside the window with a value from 9 to 15 leaves the select field unchanged, but still closes the window.
- R9: Once settled with select value S (0 to 8), `clk_en_o` pulses high for one cycle every 2^S master cycles. With S = 0 it stays high.
- R10: A new factor takes effect only at the end of the current divided period. The period in which the change was written keeps the old length.
- R11: With `clkout_en_i` high, `clk_out_o` carries the divided clock. At divide-by-1 it is the master clock itself. For larger factors it is high during the first half of each period. It keeps running while reset is asserted. With `clkout_en_i` low, it is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |
| rst_sel_i | input | 4 | Strap giving the select value loaded at reset |
| clkout_en_i | input | 1 | Strap that enables the clock output pin |
| clk_en_o | output | 1 | System clock enable, one pulse per divided period |
| clk_out_o | output | 1 | Divided clock pin |
| irq_mask_o | output | 1 | High while the unlock window is open |

## Verification
The checker assumes that `rst_sel_i` is held steady, so that any change of the select field can only come from an accepted write. It also assumes that each register write lasts a single cycle, so that every strobe counts as exactly one write. The stimulus keeps to both: the strap changes only while reset is asserted, and every write is driven for one cycle, between clock edges. The write sequences place the second write at chosen distances from the unlock write, including the last accepted cycle and the first rejected one.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
    // register and divider geometry shared by the block
    localparam int unsigned REG_W   = 8;
    localparam int unsigned SEL_W   = 4;
    localparam int unsigned MAX_EXP = 8;
    localparam int unsigned WIN_CYC = 4;
endpackage

// File: rtl/sysclk_ctrl_reg.sv
module sysclk_ctrl_reg #(
    parameter int unsigned REG_W   = sysclk_pkg::REG_W,
    parameter int unsigned SEL_W   = sysclk_pkg::SEL_W,
    parameter int unsigned MAX_EXP = sysclk_pkg::MAX_EXP,
    parameter int unsigned WIN_CYC = sysclk_pkg::WIN_CYC
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [SEL_W-1:0] rst_sel_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             armed_o
);
    localparam int unsigned AGE_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int unsigned PAD_W = REG_W - 1 - SEL_W;
    localparam logic [REG_W-1:0] UNLOCK_CODE = {1'b1, {(REG_W-1){1'b0}}};
    localparam logic [AGE_W-1:0] AGE_LAST    = AGE_W'(WIN_CYC - 1);
    localparam logic [SEL_W-1:0] SEL_MAX     = SEL_W'(MAX_EXP);

    typedef struct packed {
        logic             armed;
        logic [AGE_W-1:0] age;
        logic [SEL_W-1:0] sel;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     unlock_wr, sel_wr;
    logic [SEL_W-1:0] boot_sel;

    assign boot_sel = (rst_sel_i <= SEL_MAX) ? rst_sel_i : '0;

    always_comb begin
        st_d      = st_q;
        unlock_wr = wr_en_i && (wr_data_i == UNLOCK_CODE);
        sel_wr    = wr_en_i && !wr_data_i[REG_W-1] && st_q.armed;

        // window ageing
        if (st_q.armed) begin
            if (st_q.age == AGE_LAST) begin
                st_d.armed = 1'b0;
            end else begin
                st_d.age = st_q.age + 1'b1;
            end
        end

        // accepted select write closes the window at once
        if (sel_wr) begin
            st_d.armed = 1'b0;
            if (wr_data_i[SEL_W-1:0] <= SEL_MAX) begin
                st_d.sel = wr_data_i[SEL_W-1:0];
            end
        end

        // unlock code opens or restarts the window
        if (unlock_wr) begin
            st_d.armed = 1'b1;
            st_d.age   = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.armed <= 1'b0;
            st_q.age   <= '0;
            st_q.sel   <= boot_sel;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = {st_q.armed, {PAD_W{1'b0}}, st_q.sel};
    assign sel_o     = st_q.sel;
    assign armed_o   = st_q.armed;
endmodule

// File: rtl/sysclk_div_core.sv
module sysclk_div_core #(
    parameter int unsigned SEL_W   = sysclk_pkg::SEL_W,
    parameter int unsigned MAX_EXP = sysclk_pkg::MAX_EXP
) (
    input  logic             clk_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             clkout_en_i,
    output logic             clk_en_o,
    output logic             clk_out_o
);
    localparam int unsigned CNT_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] expo;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CNT_W-1:0] span, top_bit;
    logic             wrap, level;

    // low bits set for the active exponent, clamped to the counter width
    function automatic logic [CNT_W-1:0] span_of(input logic [SEL_W-1:0] e);
        logic [CNT_W-1:0] m;
        m = '0;
        for (int i = 0; i < int'(CNT_W); i++) begin
            if (i < int'(e)) m[i] = 1'b1;
        end
        return m;
    endfunction

    always_comb begin
        span    = span_of(st_q.expo);
        top_bit = span ^ (span >> 1);
        wrap    = ((st_q.cnt & span) == span);
        level   = ((st_q.cnt & top_bit) == '0);
        st_d    = st_q;
        if (wrap) begin
            st_d.cnt  = '0;
            st_d.expo = sel_i;   // factor switches only at the period boundary
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    // free running: no reset so the divided clock keeps going through reset
    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign clk_en_o  = wrap;
    assign clk_out_o = clkout_en_i && ((st_q.expo == '0) ? clk_i : level);
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
    parameter int unsigned REG_W   = sysclk_pkg::REG_W,
    parameter int unsigned SEL_W   = sysclk_pkg::SEL_W,
    parameter int unsigned MAX_EXP = sysclk_pkg::MAX_EXP,
    parameter int unsigned WIN_CYC = sysclk_pkg::WIN_CYC
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic [SEL_W-1:0] rst_sel_i,
    input  logic             clkout_en_i,
    output logic             clk_en_o,
    output logic             clk_out_o,
    output logic             irq_mask_o
);
    logic [SEL_W-1:0] sel;
    logic             armed;

    sysclk_ctrl_reg #(
        .REG_W(REG_W), .SEL_W(SEL_W), .MAX_EXP(MAX_EXP), .WIN_CYC(WIN_CYC)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rst_sel_i (rst_sel_i),
        .rd_data_o (rd_data_o),
        .sel_o     (sel),
        .armed_o   (armed)
    );

    sysclk_div_core #(
        .SEL_W(SEL_W), .MAX_EXP(MAX_EXP)
    ) u_div (
        .clk_i       (clk_i),
        .sel_i       (sel),
        .clkout_en_i (clkout_en_i),
        .clk_en_o    (clk_en_o),
        .clk_out_o   (clk_out_o)
    );

    assign irq_mask_o = armed;
endmodule

// File: rtl/sysclk_prescaler_chk.sv
module sysclk_prescaler_chk #(
    parameter int unsigned REG_W   = sysclk_pkg::REG_W,
    parameter int unsigned SEL_W   = sysclk_pkg::SEL_W,
    parameter int unsigned MAX_EXP = sysclk_pkg::MAX_EXP,
    parameter int unsigned WIN_CYC = sysclk_pkg::WIN_CYC
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic [REG_W-1:0] rd_data_o
);
    localparam logic [REG_W-1:0] UNLOCK_CODE = {1'b1, {(REG_W-1){1'b0}}};
    localparam int unsigned RUN_W = $clog2(WIN_CYC + 2) + 1;

    logic             arm_bit;
    logic [SEL_W-1:0] sel_f;
    logic [RUN_W-1:0] run_q;

    assign arm_bit = rd_data_o[REG_W-1];
    assign sel_f   = rd_data_o[SEL_W-1:0];

    // length of the current open window, restarted by an unlock write
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (wr_en_i && (wr_data_i == UNLOCK_CODE)) begin
            run_q <= '0;
        end else if (arm_bit) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R2
    ro_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[REG_W-2:SEL_W] == '0);

    // R3
    arm_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(arm_bit) |-> $past(wr_en_i && (wr_data_i == UNLOCK_CODE)));

    // R4
    sel_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_f != $past(sel_f)) |-> $past(wr_en_i && !wr_data_i[REG_W-1] && arm_bit));

    // R5
    window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q <= RUN_W'(WIN_CYC));

    // R5
    sel_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_data_i[REG_W-1] && arm_bit) |=> !arm_bit);

    // R8
    sel_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_f <= SEL_W'(MAX_EXP));
endmodule

bind sysclk_prescaler sysclk_prescaler_chk #(
    .REG_W(REG_W), .SEL_W(SEL_W), .MAX_EXP(MAX_EXP), .WIN_CYC(WIN_CYC)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o)
);

// File: tb/sysclk_prescaler_tb.sv
`timescale 1ns/1ps
module sysclk_prescaler_tb;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic [3:0] rst_sel_i = 4'd3;
    logic       clkout_en_i = 1'b1;
    logic       clk_en_o, clk_out_o, irq_mask_o;

    int total = 0;
    int bad   = 0;

    always #4 clk_i = ~clk_i;

    sysclk_prescaler u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .rst_sel_i(rst_sel_i), .clkout_en_i(clkout_en_i),
        .clk_en_o(clk_en_o), .clk_out_o(clk_out_o), .irq_mask_o(irq_mask_o)
    );

    typedef struct packed {
        logic [7:0] first;
        logic [3:0] gap;
        logic [7:0] second;
        logic [3:0] exp_sel;
    } vec_t;

    // unlock-sequence vectors, starting from select 3
    localparam vec_t VECS [11] = '{
        '{8'h80, 4'd0, 8'h02, 4'd2},   // R4 accepted at first edge
        '{8'h80, 4'd3, 8'h05, 4'd5},   // R4 accepted at fourth edge
        '{8'h80, 4'd4, 8'h01, 4'd5},   // R4 too late
        '{8'h81, 4'd0, 8'h01, 4'd5},   // R3 bad unlock code
        '{8'h04, 4'd0, 8'h04, 4'd5},   // R4 no unlock at all
        '{8'h80, 4'd0, 8'h0A, 4'd5},   // R8 reserved value
        '{8'h80, 4'd0, 8'h88, 4'd5},   // R3 bit 7 plus other bits
        '{8'h70, 4'd0, 8'h07, 4'd5},   // R2 upper bits alone
        '{8'h80, 4'd1, 8'h08, 4'd8},
        '{8'h80, 4'd0, 8'h00, 4'd0},
        '{8'h80, 4'd2, 8'h01, 4'd1}
    };

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    // called at a falling edge; write is taken at the next rising edge
    task automatic wr(input logic [7:0] d);
        wr_en_i = 1'b1;
        wr_data_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
        wr_data_i = 8'h00;
    endtask

    task automatic set_sel(input logic [7:0] v);
        wr(8'h80);
        wr(v);
        step(1);
    endtask

    task automatic gap(output int n);
        while (!clk_en_o) step(1);
        n = 0;
        do begin
            step(1);
            n++;
        end while (!clk_en_o);
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int toggles;
        logic prev;

        // R11 divided clock runs during reset, R1 reset state
        toggles = 0;
        step(1);
        prev = clk_out_o;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (clk_out_o != prev) toggles++;
            prev = clk_out_o;
        end
        check("R11 toggles in reset", int'(toggles >= 6), 1);
        check("R1 reset readback", rd_data_o, 8'h03);
        check("R1 reset mask", irq_mask_o, 0);
        rst_ni = 1'b1;
        step(2);
        check("R1 after release", rd_data_o, 8'h03);
        gap(n); gap(n);
        check("R9 period strap 3", n, 8);

        // vector walk
        for (int v = 0; v < 11; v++) begin
            wr(VECS[v].first);
            step(int'(VECS[v].gap));
            wr(VECS[v].second);
            step(8);
            check($sformatf("R3/R4/R8 vector %0d", v), rd_data_o, int'(VECS[v].exp_sel));
        end

        // R5 R7 window length
        wr(8'h80);
        check("R5 armed after unlock", rd_data_o, 8'h81);
        check("R7 mask open", irq_mask_o, 1);
        step(2);
        check("R5 armed third cycle", rd_data_o[7], 1);
        step(1);
        check("R7 mask fourth cycle", irq_mask_o, 1);
        step(1);
        check("R5 closed after four", rd_data_o[7], 0);
        check("R7 mask closed", irq_mask_o, 0);

        // R6 restart, R5 immediate clear
        wr(8'h80);
        step(1);
        wr(8'h80);
        step(3);
        check("R6 still open after restart", rd_data_o[7], 1);
        wr(8'h06);
        check("R6 late write accepted", rd_data_o[3:0], 6);
        check("R5 cleared by select write", rd_data_o[7], 0);

        // R9 periods
        set_sel(8'h00);
        gap(n); gap(n);
        check("R9 period divide 1", n, 1);
        set_sel(8'h08);
        gap(n); gap(n);
        check("R9 period divide 256", n, 256);

        // R10 change mid period keeps old length once
        set_sel(8'h03);
        gap(n); gap(n);
        while (!clk_en_o) step(1);
        wr(8'h80);
        wr(8'h01);
        n = 2;
        do begin
            step(1);
            n++;
        end while (!clk_en_o);
        check("R10 old period kept", n, 8);
        gap(n);
        check("R10 new period", n, 2);

        // R11 output shapes
        step(1);
        prev = clk_out_o;
        step(1);
        check("R11 divide 2 toggles", int'(clk_out_o != prev), 1);
        set_sel(8'h00);
        step(2);
        check("R11 divide 1 low phase", clk_out_o, 0);
        @(posedge clk_i); #1;
        check("R11 divide 1 high phase", clk_out_o, 1);
        @(negedge clk_i);
        clkout_en_i = 1'b0;
        toggles = 0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            if (clk_out_o) toggles++;
            @(posedge clk_i); #1;
            if (clk_out_o) toggles++;
        end
        check("R11 pin held low", toggles, 0);

        // R1 reserved strap loads zero
        @(negedge clk_i);
        rst_ni = 1'b0;
        rst_sel_i = 4'd12;
        step(3);
        rst_ni = 1'b1;
        step(2);
        check("R1 reserved strap", rd_data_o, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule